// File: doc/BRIEF.md
# Byte FIFO with Status Flags

This block is a twelve-entry byte queue that sits between a host register port and a serial transmit/receive engine. One side pushes bytes and the other side pops them. The oldest byte is always visible on the read data port. A packed 8-bit status word describes the queue. Its low nibble holds the number of unread bytes minus one. Above that sit a sticky overflow flag and two watermarks. Only the watermark that belongs to the current direction can assert: the high mark in receive mode, the low mark in transmit mode.

A 12-bit transmit-length register sits next to the queue. It holds the number of whole bytes a frame is meant to carry. The host loads its upper eight bits and its low nibble with two separate write strobes. The register returns to zero on reset, whenever the enable input is low, and when the engine signals the end of a transmit frame.

A separate empty output is provided because the minus-one count reads zero for both zero bytes and one byte.

Top module: `byteFifoStatus`

## Requirements
- R1: Bytes leave the queue in the order they entered. `popData` shows the oldest stored byte combinationally. A pop request while empty changes nothing.
- R2: The queue holds 12 bytes and `full` is high at 12. A push while full is dropped, and the stored bytes stay unchanged. This also applies when a pop is accepted in the same cycle.
- R3: Status bit 4 (overflow) is set by a push attempted while full and stays set. A cycle with `statusRead` high clears it, unless a new overflow happens in that same cycle, in which case it stays set. Reset also clears it.
- R4: Status bits 3:0 read N−1 for N stored bytes, and 0 when the queue is empty. `empty` is high exactly when N is 0.
- R5: Status bit 6 is high when `dirTx` is 0 (receive) and N ≥ 9. It is never high when `dirTx` is 1.
- R6: Status bit 5 is high when `dirTx` is 1 (transmit) and N ≤ 3. It is never high when `dirTx` is 0.
- R7: Status bit 7 always reads 0.
- R8: `lenWrHi` loads `lenWrData` into `txLen[11:4]`. `lenWrLo` loads `lenWrData[3:0]` into `txLen[3:0]`. Both take effect at the next clock edge.
- R9: `txLen` becomes 0 after reset, after any cycle with `enable` low, and after any cycle with `txEof` high. Writes made in such a cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low holds the length register at zero |
| dirTx | input | 1 | 1 = transmit, 0 = receive |
| pushValid | input | 1 | Push request |
| pushData | input | 8 | Byte to push |
| popReq | input | 1 | Pop request |
| popData | output | 8 | Oldest stored byte |
| statusRead | input | 1 | Host read of status; clears overflow |
| status | output | 8 | {0, highMark, lowMark, overflow, count−1} |
| empty | output | 1 | No bytes stored |
| full | output | 1 | Twelve bytes stored |
| lenWrHi | input | 1 | Write strobe for length bits 11:4 |
| lenWrLo | input | 1 | Write strobe for length bits 3:0 |
| lenWrData | input | 8 | Length write data |
| txEof | input | 1 | End-of-transmit-frame event |
| txLen | output | 12 | Transmit length |

## Verification
Two collisions matter. The first is a push attempted while full in the same cycle as a host status read. The bench fills the queue, raises `statusRead` and `pushValid` together, and expects the overflow bit to stay set. The second is a length write that coincides with `txEof`. The bench drives both strobes in one cycle and expects `txLen` to read zero afterwards.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  localparam int LEN_W = 12;
  localparam int LEN_LO_W = 4;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/fifoData.sv
module fifoData
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  assign popData = mem[rdPtr];

  AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && wrPtr == LAST) |=> (wrPtr == '0)); // R1
  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && rdPtr == LAST) |=> (rdPtr == '0)); // R1
endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int HIGH_MARK = 9,
  parameter int LOW_MARK = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dirTx,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             statusRead,
  input  logic             lenWrHi,
  input  logic             lenWrLo,
  input  logic [7:0]       lenWrData,
  input  logic             txEof,
  output fifoStrobe_t      strobe,
  output logic [7:0]       status,
  output logic             empty,
  output logic             full,
  output logic [LEN_W-1:0] txLen
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(HIGH_MARK);
  localparam logic [CNT_W-1:0] CNT_LOW = CNT_W'(LOW_MARK);

  logic [CNT_W-1:0] count;
  logic             ovfFlag;
  logic             ovfEvent;
  logic [7:0]       cntWide;
  logic [7:0]       cntLess;
  logic             hiMark;
  logic             loMark;

  assign full = (count == CNT_FULL);
  assign empty = (count == '0);
  assign ovfEvent = pushValid && full;
  assign strobe.push = pushValid && !full;
  assign strobe.pop = popReq && !empty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // a fresh overflow outranks the clearing read
  always_ff @(posedge clk) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (ovfEvent) ovfFlag <= 1'b1;
    else if (statusRead) ovfFlag <= 1'b0;
  end

  assign cntWide = 8'(count);
  assign cntLess = empty ? 8'd0 : cntWide - 8'd1;
  assign hiMark = !dirTx && (count >= CNT_HIGH);
  assign loMark = dirTx && (count <= CNT_LOW);
  // bit 7 is reserved and tied low (R7)
  assign status = {1'b0, hiMark, loMark, ovfFlag, cntLess[3:0]};

  always_ff @(posedge clk) begin
    if (!rstN || !enable || txEof) begin
      txLen <= '0;
    end else begin
      if (lenWrHi) txLen[LEN_W-1:LEN_LO_W] <= lenWrData[LEN_W-LEN_LO_W-1:0];
      if (lenWrLo) txLen[LEN_LO_W-1:0] <= lenWrData[LEN_LO_W-1:0];
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !popReq) |=> full); // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid) |=> status[4]); // R3
  AST_OVF_READ: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(full && pushValid)) |=> !status[4]); // R3
  AST_LEN_EOF: assert property (@(posedge clk) disable iff (!rstN)
    txEof |=> (txLen == '0)); // R9
  AST_LEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (txLen == '0)); // R9
endmodule

// File: rtl/byteFifoStatus.sv
module byteFifoStatus
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int HIGH_MARK = 9,
  parameter int LOW_MARK = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        dirTx,
  input  logic        pushValid,
  input  logic [7:0]  pushData,
  input  logic        popReq,
  output logic [7:0]  popData,
  input  logic        statusRead,
  output logic [7:0]  status,
  output logic        empty,
  output logic        full,
  input  logic        lenWrHi,
  input  logic        lenWrLo,
  input  logic [7:0]  lenWrData,
  input  logic        txEof,
  output logic [11:0] txLen
);
  fifoStrobe_t strobe;

  fifoCtrl #(
    .DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .dirTx(dirTx),
    .pushValid(pushValid), .popReq(popReq), .statusRead(statusRead),
    .lenWrHi(lenWrHi), .lenWrLo(lenWrLo), .lenWrData(lenWrData),
    .txEof(txEof), .strobe(strobe), .status(status), .empty(empty),
    .full(full), .txLen(txLen)
  );

  fifoData #(.DEPTH(DEPTH), .DATA_W(8)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushData(pushData), .popData(popData)
  );
endmodule

// File: tb/byteFifoStatus_test.sv
module byteFifoStatus_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic dirTx = 1'b0;
  logic pushValid = 1'b0;
  logic [7:0] pushData = '0;
  logic popReq = 1'b0;
  logic [7:0] popData;
  logic statusRead = 1'b0;
  logic [7:0] status;
  logic empty, full;
  logic lenWrHi = 1'b0, lenWrLo = 1'b0;
  logic [7:0] lenWrData = '0;
  logic txEof = 1'b0;
  logic [11:0] txLen;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  byteFifoStatus uut (
    .clk(clk), .rstN(rstN), .enable(enable), .dirTx(dirTx),
    .pushValid(pushValid), .pushData(pushData), .popReq(popReq),
    .popData(popData), .statusRead(statusRead), .status(status),
    .empty(empty), .full(full), .lenWrHi(lenWrHi), .lenWrLo(lenWrLo),
    .lenWrData(lenWrData), .txEof(txEof), .txLen(txLen)
  );

  // {push, pop, data, expected status}; receive mode throughout
  localparam logic [17:0] VEC [9] = '{
    {2'b10, 8'h11, 8'h00}, {2'b10, 8'h22, 8'h01}, {2'b10, 8'h33, 8'h02},
    {2'b10, 8'h44, 8'h03}, {2'b10, 8'h55, 8'h04}, {2'b10, 8'h66, 8'h05},
    {2'b10, 8'h77, 8'h06}, {2'b10, 8'h88, 8'h07}, {2'b10, 8'h99, 8'h48}
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [7:0] d);
    pushValid = 1'b1; pushData = d;
    cyc();
    pushValid = 1'b0;
  endtask

  task automatic pop();
    popReq = 1'b1;
    cyc();
    popReq = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rstN = 1'b1;
    #1;
    chk("R4 R7 reset status", 12'(status), 12'h000);
    chk("R4 reset empty", 12'(empty), 12'h001);
    chk("R2 reset full", 12'(full), 12'h000);
    chk("R9 reset txLen", txLen, 12'h000);

    for (int i = 0; i < 9; i++) begin
      pushValid = VEC[i][17]; popReq = VEC[i][16]; pushData = VEC[i][15:8];
      cyc();
      pushValid = 1'b0; popReq = 1'b0;
      chk("R4 R5 R7 table status", 12'(status), 12'(VEC[i][7:0]));
    end

    dirTx = 1'b1; #1;
    chk("R5 high mark off in transmit", 12'(status), 12'h008);
    dirTx = 1'b0; #1;
    chk("R6 low mark off in receive", 12'(status), 12'h048);

    dirTx = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chk("R1 order", 12'(popData), 12'(8'h11 * (i + 1)));
      pop();
      if (i == 4) chk("R6 four bytes no low mark", 12'(status), 12'h003);
    end
    chk("R6 low mark at three", 12'(status), 12'h022);
    dirTx = 1'b0; #1;
    chk("R6 receive three", 12'(status), 12'h002);
    for (int i = 0; i < 3; i++) begin
      chk("R1 order tail", 12'(popData), 12'(8'h11 * (i + 7)));
      pop();
    end
    chk("R4 empty status", 12'(status), 12'h000);
    chk("R4 empty flag", 12'(empty), 12'h001);
    pop();
    chk("R1 pop while empty", 12'({empty, status}), 12'h100);

    dirTx = 1'b1;
    for (int i = 0; i < 12; i++) push(8'hA0 + 8'(i));
    chk("R2 full status", 12'(status), 12'h00B);
    chk("R2 full flag", 12'(full), 12'h001);
    push(8'hEE);
    chk("R3 overflow set", 12'(status), 12'h01B);
    chk("R2 head unchanged", 12'(popData), 12'h0A0);
    pushValid = 1'b1; pushData = 8'hED; popReq = 1'b1;
    cyc();
    pushValid = 1'b0; popReq = 1'b0;
    chk("R2 push dropped with pop", 12'(status), 12'h01A);
    chk("R2 not full", 12'(full), 12'h000);
    statusRead = 1'b1; cyc(); statusRead = 1'b0;
    chk("R3 read clears", 12'(status), 12'h00A);
    push(8'hAC);
    chk("R2 refill", 12'(status), 12'h00B);
    statusRead = 1'b1; pushValid = 1'b1; pushData = 8'hEF;
    cyc();
    statusRead = 1'b0; pushValid = 1'b0;
    chk("R3 overflow wins over read", 12'(status), 12'h01B);
    for (int i = 0; i < 12; i++) begin
      chk("R2 contents intact", 12'(popData), 12'(8'hA1 + 8'(i)));
      pop();
    end
    chk("R6 R3 empty transmit", 12'(status), 12'h030);
    rstN = 1'b0; cyc(); rstN = 1'b1;
    chk("R3 reset clears overflow", 12'(status), 12'h020);

    lenWrHi = 1'b1; lenWrData = 8'hAB; cyc(); lenWrHi = 1'b0;
    chk("R8 high write", txLen, 12'hAB0);
    lenWrLo = 1'b1; lenWrData = 8'hF5; cyc(); lenWrLo = 1'b0;
    chk("R8 low write", txLen, 12'hAB5);
    enable = 1'b0; cyc();
    chk("R9 disable clears", txLen, 12'h000);
    lenWrHi = 1'b1; lenWrLo = 1'b1; lenWrData = 8'h77; cyc();
    lenWrHi = 1'b0; lenWrLo = 1'b0;
    chk("R9 write while disabled", txLen, 12'h000);
    enable = 1'b1;
    lenWrHi = 1'b1; lenWrData = 8'h12; cyc(); lenWrHi = 1'b0;
    lenWrLo = 1'b1; lenWrData = 8'h03; cyc(); lenWrLo = 1'b0;
    chk("R8 reload", txLen, 12'h123);
    txEof = 1'b1; cyc(); txEof = 1'b0;
    chk("R9 end of frame clears", txLen, 12'h000);
    lenWrHi = 1'b1; lenWrData = 8'h5A; txEof = 1'b1; cyc();
    lenWrHi = 1'b0; txEof = 1'b0;
    chk("R9 end of frame beats write", txLen, 12'h000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule